// File: doc/BRIEF.md
# Receive Mailbox Bank with Host Read Lock

This block holds a small bank of receive mailboxes for a CAN-style controller. A protocol engine outside the block presents decoded frames, each with an 11-bit standard identifier, a length code and an 8-byte payload. The bank picks one mailbox for each frame, stores the frame there and raises that mailbox's interrupt flag. Each mailbox has a state code, an identifier word, two payload words and its own 29-bit acceptance mask. A register-style host port reads and writes all of this, along with a flag register, an interrupt-enable register and a free-running 16-bit timer.

Reading a mailbox's state word locks that mailbox, so the host can copy the payload without a new frame overwriting it part way through. The lock moves when the host reads another mailbox's state word, and it is released when the host reads the timer. A frame whose only target is the locked mailbox waits in a one-entry pending slot and is stored as soon as the lock is released.

Host word addresses: 0x00 flags, 0x01 interrupt enables, 0x02 timer. Mailbox m has its state word at 0x40+4m, its identifier word at 0x41+4m, payload bytes 0..3 at 0x42+4m (byte 0 in bits 31:24) and bytes 4..7 at 0x43+4m. Its acceptance mask is at 0x80+m. State codes, held in state word bits 27:24: inactive 0x0, full 0x2, empty 0x4, overrun 0x6. The length code is in bits 19:16.

Top module: `rxmb_bank`

## Requirements
- R1: Only mailboxes whose state code is empty (0x4) or full (0x2) take part in matching, and the lowest matching index receives the frame. A frame that matches no such mailbox changes no flag.
- R2: A frame matches mailbox m when ({id, 18'b0} XOR identifier word) AND acceptance mask is zero, with the standard identifier in bits 28:18. An all-ones mask needs an exact match and an all-zero mask accepts any identifier.
- R3: A store writes the length code to state bits 19:16, the identifier to bits 28:18 of the identifier word and the payload to the two payload words. It also sets the mailbox's flag bit.
- R4: A store into a mailbox that is full with its flag set leaves code 0x6 (overrun) and the new payload. Any other store leaves code 0x2 (full).
- R5: A host read of a mailbox's state word locks that mailbox, and a locked mailbox accepts no frame. Reads of identifier, payload or flag words leave the lock unchanged.
- R6: A host read of the timer (0x02) releases the lock. The timer counts up by one every clock.
- R7: A host read of another mailbox's state word moves the lock there and frees the mailbox locked before.
- R8: A frame whose only matching mailbox is locked is held in a one-entry pending slot. A later frame that is also held replaces it. The held frame is stored within two clocks of the lock being released.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A store in the same cycle wins.
- R10: The interrupt for mailbox m is its flag AND its enable bit (bit m of address 0x01), and irqAny is the OR of all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frmValid | input | 1 | Frame present for one cycle |
| frmId | input | 11 | Standard identifier |
| frmDlc | input | 4 | Length code |
| frmData | input | 64 | Payload, byte 0 in bits 63:56 |
| hostAddr | input | 8 | Host word address |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (side effects only) |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, combinational from hostAddr |
| mbIrq | output | NUM_MB | Per-mailbox interrupt requests |
| irqAny | output | 1 | OR of all mailbox interrupts |

## Verification
The hardest state to reach is a frame held in the pending slot and then replaced before delivery. That needs a lock on the only matching mailbox, two frames arriving while the lock holds, and reads of the flag register in between to show that nothing has been delivered and that those reads do not release the lock. The bench builds this state on purpose: it disables the match-all mailbox, locks the single target through a state-word read, sends two different payloads, and then releases the lock with a timer read. It checks that the second payload is the one stored. The same pattern, with a lock moved from one mailbox to another, checks that the freed mailbox receives directly while the newly locked one defers.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  localparam int MAX_MB = 16;
  localparam int IDX_W = 4;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_FLAGS = 8'h00;
  localparam logic [ADDR_W-1:0] A_IMASK = 8'h01;
  localparam logic [ADDR_W-1:0] A_TIMER = 8'h02;

  localparam logic [3:0] CODE_IDLE  = 4'h0;
  localparam logic [3:0] CODE_FULL  = 4'h2;
  localparam logic [3:0] CODE_EMPTY = 4'h4;
  localparam logic [3:0] CODE_OVR   = 4'h6;

  typedef struct packed {
    logic [10:0] id;
    logic [3:0]  dlc;
    logic [63:0] data;
  } frame_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             store;
    logic             overrun;
    logic [IDX_W-1:0] idx;
    frame_t           frm;
  } strobe_t;
endpackage

// File: rtl/rxmb_ctrl.sv
module rxmb_ctrl
  import rxmb_pkg::*;
#(
  parameter int NUM_MB = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frmValid,
  input  frame_t                  frmIn,
  input  logic [ADDR_W-1:0]       hostAddr,
  input  logic                    hostRd,
  input  logic [NUM_MB-1:0][3:0]  codeVec,
  input  logic [NUM_MB-1:0][28:0] idVec,
  input  logic [NUM_MB-1:0][28:0] maskVec,
  input  logic [NUM_MB-1:0]       flags,
  output strobe_t                 strb
);
  logic             csRd;
  logic             timerRd;
  logic [IDX_W-1:0] csIdx;
  logic             lockValid;
  logic [IDX_W-1:0] lockIdx;
  logic             pendValid;
  frame_t           pendFrm;
  frame_t           workFrm;
  logic             workValid;
  logic [28:0]      workIdWord;
  logic [NUM_MB-1:0] cand;
  logic [NUM_MB-1:0] lockHit;
  logic [NUM_MB-1:0] avail;
  logic [IDX_W-1:0] winIdx;
  logic             winOvr;
  logic             toPend;

  assign csIdx   = hostAddr[5:2];
  assign csRd    = hostRd && (hostAddr[7:6] == 2'b01) && (hostAddr[1:0] == 2'b00)
                   && (32'(csIdx) < NUM_MB);
  assign timerRd = hostRd && (hostAddr == A_TIMER);

  // lock register: set or moved by a state-word read, cleared by a timer read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockValid <= 1'b0;
      lockIdx   <= '0;
    end else if (csRd) begin
      lockValid <= 1'b1;
      lockIdx   <= csIdx;
    end else if (timerRd) begin
      lockValid <= 1'b0;
    end
  end

  // a fresh frame takes precedence over the pending one
  always_comb begin
    workFrm   = frmValid ? frmIn : pendFrm;
    workValid = frmValid || pendValid;
  end
  assign workIdWord = {workFrm.id, 18'b0};

  for (genvar i = 0; i < NUM_MB; i++) begin : g_match
    assign cand[i] = ((codeVec[i] == CODE_EMPTY) || (codeVec[i] == CODE_FULL))
                     && (((workIdWord ^ idVec[i]) & maskVec[i]) == 29'b0);
    assign lockHit[i] = lockValid && (lockIdx == IDX_W'(i));
  end
  assign avail = cand & ~lockHit;

  // lowest index wins
  always_comb begin
    winIdx = '0;
    winOvr = 1'b0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (avail[i]) begin
        winIdx = IDX_W'(i);
        winOvr = (codeVec[i] == CODE_FULL) && flags[i];
      end
    end
  end

  assign toPend = workValid && !(|avail) && (|cand);

  always_comb begin
    strb.store   = workValid && (|avail);
    strb.overrun = winOvr;
    strb.idx     = winIdx;
    strb.frm     = workFrm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendFrm   <= '0;
    end else if (toPend) begin
      pendValid <= 1'b1;
      pendFrm   <= workFrm;
    end else if (!frmValid) begin
      pendValid <= 1'b0;
    end
  end

  // R5
  no_locked_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    csRd |=> !(strb.store && (strb.idx == $past(csIdx))));

  // R6
  timer_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timerRd && !csRd) |=> !lockValid);

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    toPend |=> pendValid);
endmodule

// File: rtl/rxmb_dp.sv
module rxmb_dp
  import rxmb_pkg::*;
#(
  parameter int NUM_MB = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [ADDR_W-1:0]       hostAddr,
  input  logic                    hostWr,
  input  logic [31:0]             hostWdata,
  output logic [31:0]             hostRdata,
  output logic [NUM_MB-1:0][3:0]  codeVec,
  output logic [NUM_MB-1:0][28:0] idVec,
  output logic [NUM_MB-1:0][28:0] maskVec,
  output logic [NUM_MB-1:0]       flags,
  output logic [NUM_MB-1:0]       mbIrq,
  output logic                    irqAny
);
  logic [3:0]  code   [NUM_MB];
  logic [3:0]  dlc    [NUM_MB];
  logic [28:0] idW    [NUM_MB];
  logic [31:0] dataLo [NUM_MB];
  logic [31:0] dataHi [NUM_MB];
  logic [28:0] accMask[NUM_MB];
  logic [NUM_MB-1:0] imask;
  logic [NUM_MB-1:0] storeHot;
  logic [NUM_MB-1:0] flagsNext;
  logic [15:0] timer;

  logic             mbSel;
  logic             maskSel;
  logic [IDX_W-1:0] mbIdx;
  logic [1:0]       mbWord;
  logic             flagWr;

  assign mbIdx   = hostAddr[5:2];
  assign mbWord  = hostAddr[1:0];
  assign mbSel   = (hostAddr[7:6] == 2'b01) && (32'(mbIdx) < NUM_MB);
  assign maskSel = (hostAddr[7:6] == 2'b10) && (32'(hostAddr[5:0]) < NUM_MB);
  assign flagWr  = hostWr && (hostAddr == A_FLAGS);

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    assign storeHot[i] = strb.store && (strb.idx == IDX_W'(i));
    assign codeVec[i]  = code[i];
    assign idVec[i]    = idW[i];
    assign maskVec[i]  = accMask[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        code[i]    <= CODE_IDLE;
        dlc[i]     <= '0;
        idW[i]     <= '0;
        dataLo[i]  <= '0;
        dataHi[i]  <= '0;
        accMask[i] <= '1;
      end else begin
        if (storeHot[i]) begin
          code[i]   <= strb.overrun ? CODE_OVR : CODE_FULL;
          dlc[i]    <= strb.frm.dlc;
          idW[i]    <= {strb.frm.id, 18'b0};
          dataLo[i] <= strb.frm.data[63:32];
          dataHi[i] <= strb.frm.data[31:0];
        end
        // a host write in the same cycle takes priority over the store
        if (hostWr && mbSel && (mbIdx == IDX_W'(i))) begin
          case (mbWord)
            2'd0: begin
              code[i] <= hostWdata[27:24];
              dlc[i]  <= hostWdata[19:16];
            end
            2'd1:    idW[i]    <= hostWdata[28:0];
            2'd2:    dataLo[i] <= hostWdata;
            default: dataHi[i] <= hostWdata;
          endcase
        end
        if (hostWr && maskSel && (hostAddr[5:0] == 6'(i))) begin
          accMask[i] <= hostWdata[28:0];
        end
      end
    end
  end

  always_comb begin
    flagsNext = flags;
    if (flagWr) flagsNext = flagsNext & ~hostWdata[NUM_MB-1:0];
    flagsNext = flagsNext | storeHot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      imask <= '0;
      timer <= '0;
    end else begin
      flags <= flagsNext;
      timer <= timer + 16'd1;
      if (hostWr && (hostAddr == A_IMASK)) imask <= hostWdata[NUM_MB-1:0];
    end
  end

  assign mbIrq  = flags & imask;
  assign irqAny = |mbIrq;

  always_comb begin
    hostRdata = '0;
    if (hostAddr == A_FLAGS)      hostRdata = 32'(flags);
    else if (hostAddr == A_IMASK) hostRdata = 32'(imask);
    else if (hostAddr == A_TIMER) hostRdata = {16'b0, timer};
    else begin
      for (int i = 0; i < NUM_MB; i++) begin
        if (mbSel && (mbIdx == IDX_W'(i))) begin
          case (mbWord)
            2'd0:    hostRdata = {4'b0, code[i], 4'b0, dlc[i], 16'b0};
            2'd1:    hostRdata = {3'b0, idW[i]};
            2'd2:    hostRdata = dataLo[i];
            default: hostRdata = dataHi[i];
          endcase
        end
        if (maskSel && (hostAddr[5:0] == 6'(i))) hostRdata = {3'b0, accMask[i]};
      end
    end
  end

  // R3
  store_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.store |=> ((flags & $past(storeHot)) != '0));

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWr && !strb.store) |=> ((flags & $past(hostWdata[NUM_MB-1:0])) == '0));

  // R6
  timer_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (timer == 16'($past(timer) + 16'd1)));
endmodule

// File: rtl/rxmb_bank.sv
module rxmb_bank
  import rxmb_pkg::*;
#(
  parameter int NUM_MB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmValid,
  input  logic [10:0]       frmId,
  input  logic [3:0]        frmDlc,
  input  logic [63:0]       frmData,
  input  logic [7:0]        hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic [NUM_MB-1:0] mbIrq,
  output logic              irqAny
);
  frame_t                  frmIn;
  strobe_t                 strb;
  logic [NUM_MB-1:0][3:0]  codeVec;
  logic [NUM_MB-1:0][28:0] idVec;
  logic [NUM_MB-1:0][28:0] maskVec;
  logic [NUM_MB-1:0]       flags;

  assign frmIn = '{id: frmId, dlc: frmDlc, data: frmData};

  initial begin
    assert (NUM_MB >= 1 && NUM_MB <= MAX_MB)
      else $error("NUM_MB out of range");
  end

  rxmb_ctrl #(.NUM_MB(NUM_MB)) ctrl_i (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmIn(frmIn),
    .hostAddr(hostAddr), .hostRd(hostRd), .codeVec(codeVec), .idVec(idVec),
    .maskVec(maskVec), .flags(flags), .strb(strb)
  );

  rxmb_dp #(.NUM_MB(NUM_MB)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .codeVec(codeVec),
    .idVec(idVec), .maskVec(maskVec), .flags(flags), .mbIrq(mbIrq),
    .irqAny(irqAny)
  );
endmodule

// File: tb/rxmb_bank_tb_top.sv
module rxmb_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frmValid = 1'b0;
  logic [10:0] frmId = '0;
  logic [3:0]  frmDlc = '0;
  logic [63:0] frmData = '0;
  logic [7:0]  hostAddr = '0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic [7:0]  mbIrq;
  logic        irqAny;

  int nChk = 0;
  int nFail = 0;

  localparam logic [31:0] FULL_ONES = 32'h1FFF_FFFF;
  localparam logic [31:0] CS_EMPTY = 32'h0400_0000;

  always #2 clk = ~clk;

  rxmb_bank #(.NUM_MB(8)) dut_i (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmId(frmId), .frmDlc(frmDlc),
    .frmData(frmData), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .mbIrq(mbIrq), .irqAny(irqAny)
  );

  function automatic logic [7:0] csA(input int m);  return 8'(8'h40 + 4 * m); endfunction
  function automatic logic [7:0] idA(input int m);  return 8'(8'h41 + 4 * m); endfunction
  function automatic logic [7:0] loA(input int m);  return 8'(8'h42 + 4 * m); endfunction
  function automatic logic [7:0] mskA(input int m); return 8'(8'h80 + m); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic send(input logic [10:0] id, input logic [3:0] dlc, input logic [63:0] data);
    @(negedge clk);
    frmId = id; frmDlc = dlc; frmData = data; frmValid = 1'b1;
    @(negedge clk);
    frmValid = 1'b0;
  endtask

  task automatic cfg(input int m, input logic [10:0] id, input logic [31:0] mask);
    wr(csA(m), 32'h0);
    wr(idA(m), {3'b0, id, 18'b0});
    wr(mskA(m), mask);
    wr(csA(m), CS_EMPTY);
  endtask

  task automatic unlock();
    logic [31:0] d;
    rd(8'h02, d);
  endtask

  task automatic t_reset();
    logic [31:0] d, t1, t2;
    rd(8'h00, d); chk("R9 reset flags", d, 32'h0);
    chk("R10 reset irq", {31'b0, irqAny}, 32'h0);
    rd(csA(0), d); chk("R1 reset code inactive", d, 32'h0);
    rd(8'h02, t1);
    rd(8'h02, t2);
    chk("R6 timer step", t2 - t1, 32'd2);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    cfg(0, 11'h301, FULL_ONES);
    cfg(1, 11'h302, FULL_ONES);
    cfg(2, 11'h301, FULL_ONES);
    cfg(3, 11'h000, 32'h0);
    send(11'h302, 4'd8, 64'h1122_3344_5566_7788);
    rd(8'h00, d); chk("R1 exact match to mb1", d, 32'h2);
    rd(csA(1), d); chk("R3 state full dlc8", d, 32'h0208_0000);
    rd(loA(1), d); chk("R3 payload low", d, 32'h1122_3344);
    unlock();
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    send(11'h301, 4'd5, 64'hAAAA_0000_0000_0001);
    rd(csA(0), d); chk("R2 lowest of mb0/mb2", d, 32'h0205_0000);
    unlock();
    send(11'h301, 4'd3, 64'hBBBB_CCCC_0000_0002);
    rd(csA(0), d); chk("R4 overrun code", d, 32'h0603_0000);
    rd(loA(0), d); chk("R4 new payload", d, 32'hBBBB_CCCC);
    unlock();
    wr(8'h00, 32'h1);
    rd(8'h00, d); chk("R9 w1c only bit0", d, 32'h2);
  endtask

  task automatic t_anyid();
    logic [31:0] d;
    send(11'h555, 4'd2, 64'h0);
    rd(8'h00, d); chk("R2 zero mask accepts", d, 32'h0A);
    rd(idA(3), d); chk("R3 id in bits 28:18", d, 32'h1554_0000);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(csA(0), CS_EMPTY);
    rd(csA(0), d); chk("R5 read rearmed mb0", d, CS_EMPTY);
    rd(idA(0), d);
    send(11'h301, 4'd1, 64'h0);
    rd(8'h00, d); chk("R5 locked mb0 skipped", d, 32'h0E);
    rd(csA(0), d); chk("R5 mb0 still empty", d, CS_EMPTY);
    unlock();
  endtask

  task automatic t_pending();
    logic [31:0] d;
    wr(csA(3), 32'h0);
    send(11'h777, 4'd1, 64'h0);
    rd(8'h00, d); chk("R1 inactive ignored", d, 32'h0E);
    cfg(4, 11'h123, FULL_ONES);
    rd(csA(4), d);
    send(11'h123, 4'd8, 64'hDEAD_0001_0000_0000);
    send(11'h123, 4'd8, 64'hBEEF_0002_0000_0000);
    rd(8'h00, d); chk("R8 held while locked", d, 32'h0E);
    unlock();
    repeat (2) @(negedge clk);
    rd(8'h00, d); chk("R8 delivered on release", d, 32'h1E);
    rd(loA(4), d); chk("R8 newer frame kept", d, 32'hBEEF_0002);
  endtask

  task automatic t_move();
    logic [31:0] d;
    cfg(5, 11'h0AA, FULL_ONES);
    cfg(6, 11'h0BB, FULL_ONES);
    rd(csA(5), d);
    rd(csA(6), d);
    send(11'h0AA, 4'd8, 64'h0);
    rd(8'h00, d); chk("R7 freed mb5 receives", d, 32'h3E);
    send(11'h0BB, 4'd8, 64'h0);
    rd(8'h00, d); chk("R7 new lock on mb6", d, 32'h3E);
    unlock();
    repeat (2) @(negedge clk);
    rd(8'h00, d); chk("R8 mb6 after release", d, 32'h7E);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF);
    rd(8'h00, d); chk("R9 clear all", d, 32'h0);
    wr(8'h01, 32'h20);
    chk("R10 no irq yet", {31'b0, irqAny}, 32'h0);
    send(11'h0AA, 4'd4, 64'h0);
    @(negedge clk);
    chk("R10 irq vector", {24'b0, mbIrq}, 32'h20);
    chk("R10 irq any", {31'b0, irqAny}, 32'h1);
    rd(csA(5), d); chk("R4 full without flag", d, 32'h0204_0000);
    unlock();
    wr(8'h00, 32'h20);
    chk("R10 irq drops", {31'b0, irqAny}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_overrun();
    t_anyid();
    t_lock();
    t_pending();
    t_move();
    t_irq();
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    #400000;
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule